// File: doc/BRIEF.md
# Eight-Pin Register-Bus GPIO with Address-Masked Data Access

This peripheral gives software control of eight general-purpose pins over a simple APB-style register bus. Each pin can be an output driven from a data register or an input. It can also be handed to a hardware alternate-function source, which then supplies both the pin value and its output enable. Inputs go through a two-flop synchronizer before anything else looks at them.

The data register uses an address-masked window. Address bits [9:2] of an access act as a per-pin mask. A read returns only the selected pins, and a write changes only the selected pins. Software can therefore set or sample one pin without a read-modify-write sequence. Each pin can also raise an interrupt on a rising, falling or either edge, or on a high or low level. The enabled events are combined into a single interrupt line.

Top module: `apb_gpio8`

## Requirements
- R1: After reset every register holds 0. All pins are software-controlled inputs: pin_oe = 0x00, pin_out = 0x00, irq = 0, and the direction register at 0x400 reads 0x00.
- R2: A read with paddr[11:10] = 0 returns the synchronized pin value in bit n when paddr[n+2] is 1, and returns 0 in bit n when paddr[n+2] is 0.
- R3: A write with paddr[11:10] = 0 loads pwdata bit n into output data bit n only where paddr[n+2] is 1. All other output data bits keep their value.
- R4: For a pin whose select bit (0x420) is 0, pin_oe bit n equals direction bit n (0x400, 1 = output) and pin_out bit n equals output data bit n.
- R5: For a pin whose select bit (0x420) is 1, pin_out and pin_oe take alt_out and alt_oe for that pin.
- R6: For a pin with sense bit (0x404) at 0, an edge latches raw status bit n (read at 0x414). With both-edges bit (0x408) at 1, either edge latches it. Otherwise polarity bit (0x40C) at 1 selects the rising edge and 0 selects the falling edge.
- R7: Writing 1 to bit n at 0x41C clears latched raw status bit n. A 0 bit in the same write leaves its status bit unchanged.
- R8: For a pin with sense bit 1, raw status bit n is 1 exactly while the synchronized pin equals polarity bit n. No clear is needed.
- R9: Masked status (0x418) is raw status AND enable (0x410, 1 = enabled). irq is the OR of all masked status bits.
- R10: A pin_in change made between clock edges k-1 and k first appears in a data read after edge k+1, and not after edge k.
- R11: Control registers read back what was written. Writes to 0x414 and 0x418 have no effect. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, combinational while psel is high and pwrite is low |
| pin_in | input | 8 | Pin input levels, asynchronous |
| alt_out | input | 8 | Hardware alternate-function output values |
| alt_oe | input | 8 | Hardware alternate-function output enables |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong output-data or direction bit shows on pin_out or pin_oe one cycle after the write that caused it. A broken mask merge shows up as a neighbouring pin moving when it should not. Lost or stuck edge-status bits show on irq two clock edges after the pin event, and again when the status registers are read back. Synchronizer depth errors shift the edge at which a held full-mask data read changes by one cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int OFS_DIR   = 'h400;
  localparam int OFS_SENSE = 'h404;
  localparam int OFS_BOTH  = 'h408;
  localparam int OFS_POL   = 'h40C;
  localparam int OFS_IE    = 'h410;
  localparam int OFS_RAW   = 'h414;
  localparam int OFS_MASK  = 'h418;
  localparam int OFS_CLR   = 'h41C;
  localparam int OFS_AF    = 'h420;

  // per-bit masked merge of a write into held data
  function automatic logic merge_bit(input logic old_v, input logic new_v, input logic sel);
    return sel ? new_v : old_v;
  endfunction

  // edge event from current and previous synchronized samples
  function automatic logic edge_hit(input logic cur, input logic prv,
                                    input logic both, input logic pol);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // level match: pin equal to the selected active level
  function automatic logic level_hit(input logic cur, input logic pol);
    return cur == pol;
  endfunction
endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_o = stage2_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_int_detect.sv
module gpio_int_detect import gpio_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] enable,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] edge_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign evt_o[i] = edge_hit(cur[i], prv[i], both[i], pol[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        edge_q[i] <= 1'b0;
      else if (sense[i]) edge_q[i] <= 1'b0;
      else               edge_q[i] <= (edge_q[i] & ~clr[i]) | evt_o[i];
    end

    assign raw_o[i] = sense[i] ? level_hit(cur[i], pol[i]) : edge_q[i];
  end

  assign edge_o   = edge_q;
  assign masked_o = raw_o & enable;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] af_sel,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] sw_data,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_mux
    assign pin_out[i] = af_sel[i] ? alt_out[i] : sw_data[i];
    assign pin_oe[i]  = af_sel[i] ? alt_oe[i]  : dir[i];
  end
endmodule

// File: rtl/apb_gpio8.sv
module apb_gpio8 import gpio_pkg::*; #(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [NPINS-1:0] pwdata,
  output logic [NPINS-1:0] prdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] alt_out,
  input  logic [NPINS-1:0] alt_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int DSPAN = NPINS + 2;

  logic [NPINS-1:0] dir_q, sense_q, both_q, pol_q, ie_q, af_q, data_q;
  logic [NPINS-1:0] sync_v, prev_v, evt_vec, edge_vec, raw_vec, masked_vec, clr_vec;
  logic [NPINS-1:0] amask, rd_val;
  logic             wr_en, in_data_win, data_wr;

  assign wr_en       = psel & penable & pwrite;
  assign in_data_win = (paddr[AW-1:DSPAN] == '0);
  assign amask       = paddr[DSPAN-1:2];
  assign data_wr     = wr_en & in_data_win;
  assign clr_vec     = (wr_en && paddr == AW'(OFS_CLR)) ? pwdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      af_q    <= '0;
    end else if (wr_en) begin
      if (paddr == AW'(OFS_DIR))   dir_q   <= pwdata;
      if (paddr == AW'(OFS_SENSE)) sense_q <= pwdata;
      if (paddr == AW'(OFS_BOTH))  both_q  <= pwdata;
      if (paddr == AW'(OFS_POL))   pol_q   <= pwdata;
      if (paddr == AW'(OFS_IE))    ie_q    <= pwdata;
      if (paddr == AW'(OFS_AF))    af_q    <= pwdata;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q[i] <= 1'b0;
      else if (data_wr) data_q[i] <= merge_bit(data_q[i], pwdata[i], amask[i]);
    end
  end

  gpio_input_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_v), .prev_o(prev_v)
  );

  gpio_int_detect #(.W(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(sync_v), .prv(prev_v), .sense(sense_q),
    .both(both_q), .pol(pol_q), .clr(clr_vec), .enable(ie_q), .evt_o(evt_vec),
    .edge_o(edge_vec), .raw_o(raw_vec), .masked_o(masked_vec), .irq_o(irq)
  );

  gpio_pin_mux #(.W(NPINS)) u_mux (
    .af_sel(af_q), .dir(dir_q), .sw_data(data_q), .alt_out(alt_out),
    .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    rd_val = '0;
    if (in_data_win)                   rd_val = sync_v & amask;
    else if (paddr == AW'(OFS_DIR))    rd_val = dir_q;
    else if (paddr == AW'(OFS_SENSE))  rd_val = sense_q;
    else if (paddr == AW'(OFS_BOTH))   rd_val = both_q;
    else if (paddr == AW'(OFS_POL))    rd_val = pol_q;
    else if (paddr == AW'(OFS_IE))     rd_val = ie_q;
    else if (paddr == AW'(OFS_RAW))    rd_val = raw_vec;
    else if (paddr == AW'(OFS_MASK))   rd_val = masked_vec;
    else if (paddr == AW'(OFS_AF))     rd_val = af_q;
  end

  assign prdata = (psel && !pwrite) ? rd_val : '0;
endmodule

// File: rtl/gpio_chk.sv
module gpio_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         data_wr,
  input logic [W-1:0] data_q,
  input logic [W-1:0] evt_vec,
  input logic [W-1:0] sense_q,
  input logic [W-1:0] edge_vec,
  input logic [W-1:0] clr_vec,
  input logic [W-1:0] ie_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] af_q,
  input logic [W-1:0] pin_oe,
  input logic         irq
);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(data_q));

  // R6
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_vec & ~sense_q) != '0) |=>
      ((edge_vec & $past(evt_vec & ~sense_q)) == $past(evt_vec & ~sense_q)));

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '1 && evt_vec == '0) |=> (edge_vec == '0));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q | af_q) == '0) |-> (pin_oe == '0));
endmodule

bind apb_gpio8 gpio_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_q(data_q),
  .evt_vec(evt_vec), .sense_q(sense_q), .edge_vec(edge_vec), .clr_vec(clr_vec),
  .ie_q(ie_q), .dir_q(dir_q), .af_q(af_q), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_apb_gpio8.sv
`timescale 1ns/1ps
module test_apb_gpio8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [7:0] pwdata = '0, prdata, pin_in = '0, alt_out = '0, alt_oe = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq;
  int         n_checks = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_gpio8 i_apb_gpio8 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference state
  bit [7:0] m_dir, m_sen, m_both, m_pol, m_ie, m_af, m_dat, m_edge, m_s1, m_s2, m_prv;

  function automatic bit [7:0] m_raw();
    bit [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_sen[i] ? (m_s2[i] == m_pol[i]) : m_edge[i];
    return r;
  endfunction

  function automatic bit [7:0] m_read(input logic [11:0] a);
    if (a[11:10] == 2'b00) return m_s2 & a[9:2];
    case (a)
      12'h400: return m_dir;
      12'h404: return m_sen;
      12'h408: return m_both;
      12'h40C: return m_pol;
      12'h410: return m_ie;
      12'h414: return m_raw();
      12'h418: return m_raw() & m_ie;
      12'h420: return m_af;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_dir, m_sen, m_both, m_pol, m_ie, m_af, m_dat, m_edge, m_s1, m_s2, m_prv} = '0;
    end else begin
      bit [7:0] nedge, clr;
      bit wr;
      wr  = psel && penable && pwrite;
      clr = (wr && paddr == 12'h41C) ? pwdata : 8'h00;
      for (int i = 0; i < 8; i++) begin
        bit rise, fall, ev;
        rise = m_s2[i] && !m_prv[i];
        fall = !m_s2[i] && m_prv[i];
        ev   = m_both[i] ? (rise || fall) : (m_pol[i] ? rise : fall);
        nedge[i] = m_sen[i] ? 1'b0 : ((m_edge[i] && !clr[i]) || ev);
      end
      m_edge = nedge;
      m_prv = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (wr) begin
        if (paddr[11:10] == 2'b00) begin
          for (int i = 0; i < 8; i++) if (paddr[i+2]) m_dat[i] = pwdata[i];
        end else case (paddr)
          12'h400: m_dir  = pwdata;
          12'h404: m_sen  = pwdata;
          12'h408: m_both = pwdata;
          12'h40C: m_pol  = pwdata;
          12'h410: m_ie   = pwdata;
          12'h420: m_af   = pwdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the pin and interrupt outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [7:0] eo, ee;
      for (int i = 0; i < 8; i++) begin
        eo[i] = m_af[i] ? alt_out[i] : m_dat[i];
        ee[i] = m_af[i] ? alt_oe[i]  : m_dir[i];
      end
      chk("R4/R5 pin_out", pin_out, eo);
      chk("R4/R5 pin_oe", pin_oe, ee);
      chk("R9 irq", {7'b0, irq}, {7'b0, |(m_raw() & m_ie)});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    chk(tag, prdata, exp);
    chk({tag, " model"}, prdata, m_read(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1 reset pin_oe", pin_oe, 8'h00);
    chk("R1 reset pin_out", pin_out, 8'h00);
    chk("R1 reset irq", {7'b0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    rd("R1 dir after reset", 12'h400, 8'h00);

    // R3 / R4: masked writes to the data window
    wr(12'h400, 8'hF0);
    wr(12'h0C0, 8'hFF);
    wr(12'h040, 8'h00);
    @(negedge clk);
    chk("R3 pin_out after masked writes", pin_out, 8'h20);
    chk("R4 pin_oe from direction", pin_oe, 8'hF0);

    // R2: masked reads of synchronized input
    pin_in = 8'hA5;
    idle(3);
    rd("R2 full mask read", 12'h3FC, 8'hA5);
    rd("R2 low nibble read", 12'h03C, 8'h05);

    // R10: synchronizer latency with a held read
    @(negedge clk); psel = 1; penable = 1; pwrite = 0; paddr = 12'h3FC; pin_in = 8'h5A;
    @(negedge clk); #1 chk("R10 read after one edge", prdata, 8'hA5);
    @(negedge clk); #1 chk("R10 read after two edges", prdata, 8'h5A);
    psel = 0; penable = 0;

    // R5: alternate function on pins 0 and 1
    alt_out = 8'h01; alt_oe = 8'h02;
    wr(12'h420, 8'h03);
    @(negedge clk);
    chk("R5 pin_out alt", pin_out, 8'h21);
    chk("R5 pin_oe alt", pin_oe, 8'hF2);
    rd("R11 select readback", 12'h420, 8'h03);

    // R6 / R7: edges; A5->5A latched falling edges on 7,5,2,0
    rd("R6 default falling latch", 12'h414, 8'hA5);
    wr(12'h41C, 8'hFF);
    rd("R7 clear all", 12'h414, 8'h00);
    wr(12'h408, 8'h04);
    wr(12'h40C, 8'h01);
    wr(12'h410, 8'hFF);
    pin_in = 8'h5B; idle(4);
    rd("R6 rising pin0", 12'h414, 8'h01);
    wr(12'h41C, 8'h02);
    rd("R7 zero bit no effect", 12'h414, 8'h01);
    wr(12'h41C, 8'h01);
    rd("R7 clear pin0", 12'h414, 8'h00);
    pin_in = 8'h5F; idle(4);
    rd("R6 both-edges rise pin2", 12'h414, 8'h04);
    wr(12'h41C, 8'h04);
    pin_in = 8'h5B; idle(4);
    rd("R6 both-edges fall pin2", 12'h414, 8'h04);
    wr(12'h41C, 8'h04);
    pin_in = 8'h59; idle(4);
    rd("R6 falling pin1", 12'h414, 8'h02);

    // R9 / R11: masked status, read-only writes
    wr(12'h410, 8'hFD);
    rd("R9 masked status", 12'h418, 8'h00);
    @(negedge clk);
    chk("R9 irq masked off", {7'b0, irq}, 8'h00);
    wr(12'h414, 8'hFF);
    wr(12'h418, 8'hFF);
    rd("R11 raw unaffected by write", 12'h414, 8'h02);
    wr(12'h41C, 8'h02);

    // R8: level sensing on pin3 (high level)
    wr(12'h404, 8'h08);
    wr(12'h40C, 8'h09);
    rd("R8 level high active", 12'h414, 8'h08);
    rd("R9 masked level", 12'h418, 8'h08);
    @(negedge clk);
    chk("R9 irq from level", {7'b0, irq}, 8'h01);
    pin_in = 8'h51; idle(4);
    rd("R8 level released", 12'h414, 8'h00);

    rd("R11 unmapped read", 12'h500, 8'h00);
    rd("R11 sense readback", 12'h404, 8'h08);
    idle(2);
    finish_run();
  end
endmodule